// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of a two-channel frequency synthesizer. Each channel holds a digital model of a dual-modulus prescaler, a 7-bit swallow counter and an 11-bit main counter. Each channel emits one comparison pulse for every P×N+A cycles of the fast input clock, where P is the smaller prescaler modulus.

At the start of every output period the prescaler divides by P+1. It keeps doing so until the swallow counter has counted A prescaler outputs. It then divides by P for the remaining N−A prescaler outputs. The divider drives its own modulus-control signal, and that signal is brought out so that the swallow phase can be observed.

The two channels differ only in their prescaler pairs:
- The low-band channel runs 16/17 when its select bit is 1 and 32/33 when it is 0.
- The high-band channel runs 32/33 when its select bit is 1 and 64/65 when it is 0.

A new setting of A, N and select is captured by a one-cycle load strobe. It is checked for legality and held back until the running output period ends.

Top module: `swallow_fb_divider`

## Requirements
- R1: On the low-band channel, consecutive `lo_pulse_o` pulses are P×N+A clock cycles apart, with P=16 when select is 1 and P=32 when select is 0.
- R2: On the high-band channel, consecutive `hi_pulse_o` pulses are P×N+A clock cycles apart, with P=32 when select is 1 and P=64 when select is 0.
- R3: Each output pulse is high for exactly one clock cycle.
- R4: Within each output period, the modulus-control output is high for exactly A×(P+1) cycles. These cycles start in the cycle in which the pulse is high, and the output stays low for the rest of the period.
- R5: When A is 0, the modulus-control output stays low for the whole period and the pulse spacing is P×N.
- R6: A setting loaded during an output period does not change that period. It applies from the period that begins with the next pulse.
- R7: A load with N below 3 or with N not greater than A is illegal. Such a load sets the error output in the cycle after the strobe and leaves the previous legal setting in use.
- R8: A legal load clears the error output in the cycle after the strobe.
- R9: After reset the pulse, modulus-control and error outputs are low. Each channel runs with A=0, N=3 and select 0, so the low-band spacing is 96 cycles and the high-band spacing is 192 cycles.
- R10: The extreme settings are divided exactly: A=127 with N=2047, and A=127 with N=128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock (the divided signal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lo_load_i | input | 1 | Low-band setting strobe, one cycle |
| lo_a_i | input | 7 | Low-band swallow value A |
| lo_n_i | input | 11 | Low-band main count N |
| lo_sel_i | input | 1 | Low-band prescaler select (1: 16/17, 0: 32/33) |
| lo_pulse_o | output | 1 | Low-band comparison pulse |
| lo_modctl_o | output | 1 | Low-band modulus control (1: divide by P+1) |
| lo_err_o | output | 1 | Low-band illegal-setting flag |
| hi_load_i | input | 1 | High-band setting strobe, one cycle |
| hi_a_i | input | 7 | High-band swallow value A |
| hi_n_i | input | 11 | High-band main count N |
| hi_sel_i | input | 1 | High-band prescaler select (1: 32/33, 0: 64/65) |
| hi_pulse_o | output | 1 | High-band comparison pulse |
| hi_modctl_o | output | 1 | High-band modulus control (1: divide by P+1) |
| hi_err_o | output | 1 | High-band illegal-setting flag |

## Verification
The bench builds the block with its default prescaler pairs: 16/17 and 32/33 on the low band, and 32/33 and 64/65 on the high band. All four moduli are therefore exercised through the select bits. Random settings keep N small so that many periods fit the run. Directed cases reach the widest and tightest swallow settings, namely A=127 with N=2047 on the 16/17 pair and A=127 with N=128 on the 32/33 pair, together with the two forms of illegal setting. Because each load is placed in the first cycle of a period, the bench can measure in one pass both the period that must keep the old setting and the period that follows, which must use the new one.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int A_W   = 7;
  localparam int N_W   = 11;
  localparam int N_MIN = 3;

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [N_W-1:0] n;
    logic           sel;
  } swd_cfg_t;

  localparam swd_cfg_t CFG_RST = '{a: '0, n: N_W'(N_MIN), sel: 1'b0};

  function automatic logic cfg_legal(swd_cfg_t c);
    return (c.n >= N_W'(N_MIN)) && (c.n > N_W'(c.a));
  endfunction
endpackage

// File: rtl/swd_cfg_shadow.sv
module swd_cfg_shadow
  import swd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  swd_cfg_t cfg_i,
  input  logic     take_i,
  output swd_cfg_t nxt_o,
  output logic     act_sel_o,
  output logic     err_o
);
  swd_cfg_t act_q, pend_q;
  logic     pend_vld_q, err_q, legal;

  assign legal     = cfg_legal(cfg_i);
  assign nxt_o     = pend_vld_q ? pend_q : act_q;
  assign act_sel_o = act_q.sel;
  assign err_o     = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= CFG_RST;
      pend_q     <= CFG_RST;
      pend_vld_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (take_i) act_q <= nxt_o;
      // a load in the boundary cycle waits for the following boundary
      if (load_i && legal) begin
        pend_q     <= cfg_i;
        pend_vld_q <= 1'b1;
      end else if (take_i) begin
        pend_vld_q <= 1'b0;
      end
      if (load_i) err_q <= !legal;
    end
  end
endmodule

// File: rtl/swd_prescaler.sv
module swd_prescaler #(
  parameter int P_SEL1 = 16,
  parameter int P_SEL0 = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic mod_hi_i,
  output logic tick_o
);
  localparam int P_MAX = ((P_SEL1 > P_SEL0) ? P_SEL1 : P_SEL0) + 1;
  localparam int CW    = $clog2(P_MAX + 1);

  logic [CW-1:0] cnt_q, last;

  always_comb begin
    if (sel_i) last = mod_hi_i ? CW'(P_SEL1) : CW'(P_SEL1 - 1);
    else       last = mod_hi_i ? CW'(P_SEL0) : CW'(P_SEL0 - 1);
  end

  assign tick_o = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/swd_swallow.sv
module swd_swallow
  import swd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  swd_cfg_t nxt_i,
  output logic     wrap_o,
  output logic     mod_hi_o
);
  logic [A_W-1:0] a_left_q;
  logic [N_W-1:0] n_left_q;

  assign wrap_o   = tick_i && (n_left_q == N_W'(1));
  assign mod_hi_o = (a_left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_left_q <= CFG_RST.a;
      n_left_q <= CFG_RST.n;
    end else if (wrap_o) begin
      a_left_q <= nxt_i.a;
      n_left_q <= nxt_i.n;
    end else if (tick_i) begin
      n_left_q <= n_left_q - N_W'(1);
      if (mod_hi_o) a_left_q <= a_left_q - A_W'(1);
    end
  end
endmodule

// File: rtl/swd_channel.sv
module swd_channel
  import swd_pkg::*;
#(
  parameter int P_SEL1 = 16,
  parameter int P_SEL0 = 32
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  swd_cfg_t cfg_i,
  output logic     pulse_o,
  output logic     modctl_o,
  output logic     err_o
);
  swd_cfg_t nxt;
  logic     act_sel, tick, wrap, mod_hi, pulse_q;

  swd_cfg_shadow u_shadow (
    .clk_i, .rst_ni, .load_i, .cfg_i,
    .take_i(wrap), .nxt_o(nxt), .act_sel_o(act_sel), .err_o
  );

  swd_prescaler #(.P_SEL1(P_SEL1), .P_SEL0(P_SEL0)) u_psc (
    .clk_i, .rst_ni, .sel_i(act_sel), .mod_hi_i(mod_hi), .tick_o(tick)
  );

  swd_swallow u_swallow (
    .clk_i, .rst_ni, .tick_i(tick), .nxt_i(nxt),
    .wrap_o(wrap), .mod_hi_o(mod_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= wrap;
  end

  assign pulse_o  = pulse_q;
  assign modctl_o = mod_hi;
endmodule

// File: rtl/swallow_fb_divider.sv
module swallow_fb_divider
  import swd_pkg::*;
#(
  parameter int LO_P_SEL1 = 16,
  parameter int LO_P_SEL0 = 32,
  parameter int HI_P_SEL1 = 32,
  parameter int HI_P_SEL0 = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           lo_load_i,
  input  logic [A_W-1:0] lo_a_i,
  input  logic [N_W-1:0] lo_n_i,
  input  logic           lo_sel_i,
  output logic           lo_pulse_o,
  output logic           lo_modctl_o,
  output logic           lo_err_o,
  input  logic           hi_load_i,
  input  logic [A_W-1:0] hi_a_i,
  input  logic [N_W-1:0] hi_n_i,
  input  logic           hi_sel_i,
  output logic           hi_pulse_o,
  output logic           hi_modctl_o,
  output logic           hi_err_o
);
  swd_cfg_t lo_cfg, hi_cfg;

  assign lo_cfg = '{a: lo_a_i, n: lo_n_i, sel: lo_sel_i};
  assign hi_cfg = '{a: hi_a_i, n: hi_n_i, sel: hi_sel_i};

  swd_channel #(.P_SEL1(LO_P_SEL1), .P_SEL0(LO_P_SEL0)) u_lo (
    .clk_i, .rst_ni, .load_i(lo_load_i), .cfg_i(lo_cfg),
    .pulse_o(lo_pulse_o), .modctl_o(lo_modctl_o), .err_o(lo_err_o)
  );

  swd_channel #(.P_SEL1(HI_P_SEL1), .P_SEL0(HI_P_SEL0)) u_hi (
    .clk_i, .rst_ni, .load_i(hi_load_i), .cfg_i(hi_cfg),
    .pulse_o(hi_pulse_o), .modctl_o(hi_modctl_o), .err_o(hi_err_o)
  );
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
  parameter int P_MIN = 16,
  parameter int GW    = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic load_i,
  input logic pulse_i,
  input logic modctl_i,
  input logic err_i
);
  localparam int GAP_MIN = 3 * P_MIN - 2;

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gap_q <= '0;
    else if (pulse_i)           gap_q <= '0;
    else if (gap_q != '1)       gap_q <= gap_q + GW'(1);
  end

  a_r3_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> !pulse_i);

  a_r4_modctl_rise_at_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(modctl_i) |-> pulse_i);

  a_r4_modctl_fall_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(modctl_i) |-> !pulse_i);

  a_r7_err_only_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> $stable(err_i));

  a_r1_min_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |-> (gap_q >= GW'(GAP_MIN)));
endmodule

bind swallow_fb_divider swd_checker #(.P_MIN(LO_P_SEL1)) u_chk_lo (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(lo_load_i),
  .pulse_i(lo_pulse_o), .modctl_i(lo_modctl_o), .err_i(lo_err_o)
);

bind swallow_fb_divider swd_checker #(.P_MIN(HI_P_SEL1)) u_chk_hi (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(hi_load_i),
  .pulse_i(hi_pulse_o), .modctl_i(hi_modctl_o), .err_i(hi_err_o)
);

// File: tb/swallow_fb_divider_tb_top.sv
module swallow_fb_divider_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 195000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic       lo_load = 1'b0, hi_load = 1'b0;
  logic [6:0] lo_a = '0, hi_a = '0;
  logic [10:0] lo_n = 11'd3, hi_n = 11'd3;
  logic       lo_sel = 1'b0, hi_sel = 1'b0;
  logic lo_pulse, lo_modctl, lo_err, hi_pulse, hi_modctl, hi_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_fb_divider dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lo_load_i(lo_load), .lo_a_i(lo_a), .lo_n_i(lo_n), .lo_sel_i(lo_sel),
    .lo_pulse_o(lo_pulse), .lo_modctl_o(lo_modctl), .lo_err_o(lo_err),
    .hi_load_i(hi_load), .hi_a_i(hi_a), .hi_n_i(hi_n), .hi_sel_i(hi_sel),
    .hi_pulse_o(hi_pulse), .hi_modctl_o(hi_modctl), .hi_err_o(hi_err)
  );

  function automatic int pval(int ch, bit sel);
    if (ch == 0) return sel ? 16 : 32;
    return sel ? 32 : 64;
  endfunction

  function automatic int exp_len(int ch, int a, int n, bit sel);
    return pval(ch, sel) * n + a;
  endfunction

  function automatic int exp_mh(int ch, int a, bit sel);
    return a * (pval(ch, sel) + 1);
  endfunction

  function automatic logic pulse_of(int ch);
    return (ch == 0) ? lo_pulse : hi_pulse;
  endfunction

  function automatic logic modctl_of(int ch);
    return (ch == 0) ? lo_modctl : hi_modctl;
  endfunction

  function automatic logic err_of(int ch);
    return (ch == 0) ? lo_err : hi_err;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_load(int ch, bit ld, int a, int n, bit sel);
    if (ch == 0) begin
      lo_load = ld; lo_a = 7'(a); lo_n = 11'(n); lo_sel = sel;
    end else begin
      hi_load = ld; hi_a = 7'(a); hi_n = 11'(n); hi_sel = sel;
    end
  endtask

  task automatic wait_pulse(int ch);
    while (!pulse_of(ch)) @(negedge clk);
  endtask

  // starts at a pulse sample, returns at the next pulse sample
  task automatic measure(int ch, output int len, output int mh);
    len = 0; mh = 0;
    do begin
      if (modctl_of(ch)) mh++;
      len++;
      @(negedge clk);
      if (len == 1) chk("R3", "pulse width", int'(pulse_of(ch)), 0);
    end while (!pulse_of(ch));
  endtask

  // loads in the pulse cycle, returns the length of the period in progress
  task automatic load_mid(int ch, int a, int n, bit sel, output int len, output bit err);
    drive_load(ch, 1'b1, a, n, sel);
    len = 0; err = 1'b0;
    do begin
      len++;
      @(negedge clk);
      if (len == 1) begin
        drive_load(ch, 1'b0, a, n, sel);
        err = err_of(ch);
      end
    end while (!pulse_of(ch));
  endtask

  task automatic run_cfg(int ch, int a, int n, bit sel, int old_len,
                         string req, output int new_len);
    int len, mh;
    bit err;
    load_mid(ch, a, n, sel, len, err);
    chk("R6", "period in progress", len, old_len);
    chk("R8", "err after legal load", int'(err), 0);
    measure(ch, len, mh);
    chk(req, "period", len, exp_len(ch, a, n, sel));
    chk("R4", "modctl high cycles", mh, exp_mh(ch, a, sel));
    new_len = len;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R6 watchdog: actual=%0d expected=completion", WD_CYCLES);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int len, mh, cur, rnd;
    bit err;
    rnd = int'($urandom(32'h5eed_0017));
    repeat (4) @(negedge clk);
    chk("R9", "lo pulse in reset", int'(lo_pulse), 0);
    chk("R9", "hi pulse in reset", int'(hi_pulse), 0);
    chk("R9", "lo modctl in reset", int'(lo_modctl), 0);
    chk("R9", "hi err in reset", int'(hi_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "lo err after reset", int'(lo_err), 0);

    for (int ch = 0; ch < 2; ch++) begin
      wait_pulse(ch);
      measure(ch, len, mh);
      chk("R9", "default period", len, 3 * pval(ch, 1'b0));
      chk("R5", "default modctl cycles", mh, 0);
      cur = len;

      // A = 0 on the fast pair
      run_cfg(ch, 0, 5, 1'b1, cur, "R5", cur);

      for (int i = 0; i < 10; i++) begin
        int n, a;
        bit sel;
        n   = 3 + int'($urandom % 18);
        a   = int'($urandom % n);
        sel = 1'($urandom);
        run_cfg(ch, a, n, sel, cur, (ch == 0) ? "R1" : "R2", cur);
      end

      // illegal: N not greater than A
      load_mid(ch, 4, 4, 1'b0, len, err);
      chk("R7", "err after N<=A", int'(err), 1);
      chk("R6", "period in progress", len, cur);
      measure(ch, len, mh);
      chk("R7", "setting kept after N<=A", len, cur);

      // illegal: N below 3
      load_mid(ch, 0, 2, 1'b1, len, err);
      chk("R7", "err after N<3", int'(err), 1);
      measure(ch, len, mh);
      chk("R7", "setting kept after N<3", len, cur);

      // legal load clears the flag
      run_cfg(ch, 2, 7, 1'b0, cur, (ch == 0) ? "R1" : "R2", cur);
    end

    // tight swallow on the high-band 32/33 pair
    run_cfg(1, 127, 128, 1'b1, cur, "R10", cur);
    // widest setting on the low-band 16/17 pair, run last
    wait_pulse(0);
    measure(0, cur, mh);
    run_cfg(0, 127, 2047, 1'b1, cur, "R10", cur);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule